// File: doc/BRIEF.md
# Status Register Write Controller

This block holds the processor's current status word and one saved status word. It carries out the move-to-status operation. The operand is either a full register value or an 8-bit constant rotated right by twice a 4-bit amount. Two field-select bits choose which parts of the target register may change. Writes to the current word are also limited by privilege, so code running in the unprivileged mode can change only the condition flags. The mode field, the interrupt-disable bits and the flags can all be seen on the outputs. A read port returns either register as a packed word.

A write is applied on the clock edge at which the strobe is sampled. The read data is a combinational view of the registers. Reloading banked registers when the mode changes, and exception entry, are left to other blocks.

Top module: `psr_write_ctrl`

## Requirements
- R1: After reset the current word is 0x000000D3, meaning supervisor mode 5'b10011 with both interrupt-disable bits 7 and 6 set. The saved word is 0x00000000 and `mode_o` is 5'b10011.
- R2: A write to the current word with the flags field selected (`fld_flags_i`, taken from instruction bit 19) copies operand bits [31:28] into the word on the next clock edge. Bits [27:24] stay unchanged.
- R3: In any mode other than user (5'b10000), a write to the current word with the control field selected (`fld_ctrl_i`, taken from instruction bit 16) copies operand bits 7, 6 and [3:0]. Bit 4 stays 1, so the new mode is {1, operand[3:0]}.
- R4: In user mode a control-field write to the current word leaves bits [7:0] unchanged, while a flags-field write in the same mode still takes effect.
- R5: No write ever changes bit 5 or bits [27:8] of the current word.
- R6: In any mode, a write to the saved word (`wr_saved_i`=1) changes only bits [31:28] when flags are selected, and only bits 7, 6, 5 and [3:0] when control is selected.
- R7: With `wr_imm_i`=1 the operand is `imm8_i`, zero-extended and rotated right by 2*`rot_i`. Otherwise it is `reg_op_i`.
- R8: `rd_data_o` returns the whole saved word when `rd_saved_i`=1 and the whole current word otherwise, in the same cycle.
- R9: A strobe with neither field selected, or no strobe at all, leaves both words unchanged.
- R10: A write to one target never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_saved_i | input | 1 | Target: 1 saved word, 0 current word |
| wr_imm_i | input | 1 | Operand source: 1 rotated constant, 0 register |
| fld_ctrl_i | input | 1 | Control field [7:0] selected |
| fld_flags_i | input | 1 | Flags field [31:24] selected |
| reg_op_i | input | 32 | Register operand |
| imm8_i | input | 8 | Constant before rotation |
| rot_i | input | 4 | Half of the rotate-right amount |
| rd_saved_i | input | 1 | Read select: 1 saved word, 0 current word |
| rd_data_o | output | 32 | Selected word |
| cur_psr_o | output | 32 | Current word |
| saved_psr_o | output | 32 | Saved word |
| mode_o | output | 5 | Current mode field |

## Verification
Random sequences mix both targets, both operand sources, all four field combinations and full random operands. A random control write drops into user mode once in sixteen, so the privilege lock is exercised over long stretches, and repeated resets bring the block back to privileged mode. Directed cases cover:
- entry into user mode, to tell the privilege gate apart from the field gate;
- operands with bit 5 and bit 4 set, to tell the current-word mask apart from the saved-word mask;
- constants whose rotation wraps across bit 31;
- strobes that select no field, to separate the field decode from the strobe.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_W  = 32;
  localparam int unsigned MODE_W = 5;

  // bit classes
  localparam logic [PSR_W-1:0] FLAG_BITS   = 32'hF000_0000;
  localparam logic [PSR_W-1:0] PRIV_BITS   = 32'h0000_00CF;
  localparam logic [PSR_W-1:0] STATE_BITS  = 32'h0000_0020;
  // field selects
  localparam logic [PSR_W-1:0] FLAGS_FIELD = 32'hFF00_0000;
  localparam logic [PSR_W-1:0] CTRL_FIELD  = 32'h0000_00FF;

  localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SUPV = 5'b10011;
  localparam logic [PSR_W-1:0]  CUR_RST   = 32'h0000_00D3;
  localparam logic [PSR_W-1:0]  SAV_RST   = 32'h0000_0000;

  typedef struct packed {
    logic [PSR_W-1:0] cur;
    logic [PSR_W-1:0] sav;
  } wmask_t;
endpackage

// File: rtl/psr_operand.sv
module psr_operand #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic             imm_sel_i,
  input  logic [W-1:0]     reg_op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [ROT_W-1:0] rot_i,
  output logic [W-1:0]     op_o
);
  localparam int unsigned SH_W = $clog2(2 * W);

  logic [W-1:0]    imm_ext;
  logic [SH_W-1:0] amt;
  logic [2*W-1:0]  dbl;

  always_comb begin
    imm_ext = W'(imm_i);
    amt     = SH_W'({rot_i, 1'b0});
    dbl     = {imm_ext, imm_ext} >> amt;
    op_o    = imm_sel_i ? dbl[W-1:0] : reg_op_i;
  end
endmodule

// File: rtl/psr_mask_gen.sv
module psr_mask_gen
  import psr_pkg::*;
(
  input  logic   fld_ctrl_i,
  input  logic   fld_flags_i,
  input  logic   priv_i,
  output wmask_t mask_o
);
  logic [PSR_W-1:0] field;

  always_comb begin
    field      = (fld_ctrl_i ? CTRL_FIELD : '0) | (fld_flags_i ? FLAGS_FIELD : '0);
    mask_o.cur = (field & FLAG_BITS) | (priv_i ? (field & PRIV_BITS) : '0);
    mask_o.sav = field & (FLAG_BITS | PRIV_BITS | STATE_BITS);
  end
endmodule

// File: rtl/psr_regs.sv
module psr_regs
  import psr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_saved_i,
  input  wmask_t           mask_i,
  input  logic [PSR_W-1:0] op_i,
  output logic [PSR_W-1:0] cur_o,
  output logic [PSR_W-1:0] sav_o
);
  logic [PSR_W-1:0] cur_q, sav_q, cur_d, sav_d;

  always_comb begin
    cur_d = cur_q;
    sav_d = sav_q;
    if (wr_en_i && !wr_saved_i) begin
      cur_d = (cur_q & ~mask_i.cur) | (op_i & mask_i.cur);
      // mode MSB forced high on any control update
      if (|(mask_i.cur & PRIV_BITS)) cur_d[MODE_W-1] = 1'b1;
    end
    if (wr_en_i && wr_saved_i) sav_d = (sav_q & ~mask_i.sav) | (op_i & mask_i.sav);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= CUR_RST;
      sav_q <= SAV_RST;
    end else begin
      cur_q <= cur_d;
      sav_q <= sav_d;
    end
  end

  assign cur_o = cur_q;
  assign sav_o = sav_q;
endmodule

// File: rtl/psr_write_ctrl.sv
module psr_write_ctrl
  import psr_pkg::*;
#(
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_saved_i,
  input  logic              wr_imm_i,
  input  logic              fld_ctrl_i,
  input  logic              fld_flags_i,
  input  logic [PSR_W-1:0]  reg_op_i,
  input  logic [IMM_W-1:0]  imm8_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              rd_saved_i,
  output logic [PSR_W-1:0]  rd_data_o,
  output logic [PSR_W-1:0]  cur_psr_o,
  output logic [PSR_W-1:0]  saved_psr_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [PSR_W-1:0] op, cur, sav;
  logic             priv;
  wmask_t           mask;

  psr_operand #(.W(PSR_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_operand (
    .imm_sel_i (wr_imm_i),
    .reg_op_i  (reg_op_i),
    .imm_i     (imm8_i),
    .rot_i     (rot_i),
    .op_o      (op)
  );

  assign priv = (cur[MODE_W-1:0] != MODE_USER);

  psr_mask_gen u_mask (
    .fld_ctrl_i  (fld_ctrl_i),
    .fld_flags_i (fld_flags_i),
    .priv_i      (priv),
    .mask_o      (mask)
  );

  psr_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_saved_i (wr_saved_i),
    .mask_i     (mask),
    .op_i       (op),
    .cur_o      (cur),
    .sav_o      (sav)
  );

  assign rd_data_o   = rd_saved_i ? sav : cur;
  assign cur_psr_o   = cur;
  assign saved_psr_o = sav;
  assign mode_o      = cur[MODE_W-1:0];
endmodule

// File: rtl/psr_write_ctrl_chk.sv
module psr_write_ctrl_chk
  import psr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_saved_i,
  input logic              fld_ctrl_i,
  input logic              fld_flags_i,
  input logic [PSR_W-1:0]  cur_psr_o,
  input logic [PSR_W-1:0]  saved_psr_o,
  input logic [MODE_W-1:0] mode_o
);
  a_r4_user_ctrl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_saved_i && mode_o == MODE_USER) |=> $stable(cur_psr_o[7:0]));

  a_r5_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($stable(cur_psr_o[27:8]) && $stable(cur_psr_o[5])));

  a_r3_mode_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[MODE_W-1]);

  a_r6_saved_bit4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(saved_psr_o[27:8]) && $stable(saved_psr_o[4]));

  a_r9_no_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || (!fld_ctrl_i && !fld_flags_i)) |=> ($stable(cur_psr_o) && $stable(saved_psr_o)));

  a_r10_cur_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_saved_i) |=> $stable(saved_psr_o));

  a_r10_sav_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_saved_i) |=> $stable(cur_psr_o));
endmodule

bind psr_write_ctrl psr_write_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_saved_i  (wr_saved_i),
  .fld_ctrl_i  (fld_ctrl_i),
  .fld_flags_i (fld_flags_i),
  .cur_psr_o   (cur_psr_o),
  .saved_psr_o (saved_psr_o),
  .mode_o      (mode_o)
);

// File: tb/psr_write_ctrl_bench.sv
module psr_write_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_saved_i = 1'b0, wr_imm_i = 1'b0;
  logic        fld_ctrl_i = 1'b0, fld_flags_i = 1'b0, rd_saved_i = 1'b0;
  logic [31:0] reg_op_i = '0;
  logic [7:0]  imm8_i = '0;
  logic [3:0]  rot_i = '0;
  logic [31:0] rd_data_o, cur_psr_o, saved_psr_o;
  logic [4:0]  mode_o;

  int unsigned n_run = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] m_cur, m_sav;

  always #10 clk_i = ~clk_i;

  psr_write_ctrl u_psr_write_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_saved_i(wr_saved_i),
    .wr_imm_i(wr_imm_i), .fld_ctrl_i(fld_ctrl_i), .fld_flags_i(fld_flags_i),
    .reg_op_i(reg_op_i), .imm8_i(imm8_i), .rot_i(rot_i), .rd_saved_i(rd_saved_i),
    .rd_data_o(rd_data_o), .cur_psr_o(cur_psr_o), .saved_psr_o(saved_psr_o), .mode_o(mode_o)
  );

  function automatic logic [31:0] rotr(logic [31:0] v, int n);
    logic [31:0] r = v;
    for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " cur"}, cur_psr_o, m_cur);
    check({req, " sav"}, saved_psr_o, m_sav);
    check({req, " mode"}, {27'd0, mode_o}, {27'd0, m_cur[4:0]});
    check({req, " R8 read"}, rd_data_o, rd_saved_i ? m_sav : m_cur);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    wr_en_i = 1'b0;
    #3;
    m_cur = 32'h0000_00D3;
    m_sav = 32'h0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // drive at negedge, apply model, check at the following negedge
  task automatic do_op(bit en, bit sv, bit im, bit fc, bit ff, logic [31:0] op,
                       logic [7:0] i8, logic [3:0] rt, bit rds, string req);
    logic [31:0] o;
    wr_en_i = en; wr_saved_i = sv; wr_imm_i = im; fld_ctrl_i = fc; fld_flags_i = ff;
    reg_op_i = op; imm8_i = i8; rot_i = rt; rd_saved_i = rds;
    o = im ? rotr({24'd0, i8}, 2 * rt) : op;
    if (en && !sv) begin
      if (ff) m_cur[31:28] = o[31:28];
      if (fc && m_cur[4:0] != 5'b10000) begin
        m_cur[7:6] = o[7:6];
        m_cur[3:0] = o[3:0];
        m_cur[4]   = 1'b1;
      end
    end else if (en && sv) begin
      if (ff) m_sav[31:28] = o[31:28];
      if (fc) begin
        m_sav[7:5] = o[7:5];
        m_sav[3:0] = o[3:0];
      end
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check_all(req);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    #1;
    check("R1 cur", cur_psr_o, 32'h0000_00D3);
    check("R1 sav", saved_psr_o, 32'h0);
    check("R1 mode", {27'd0, mode_o}, 32'h13);
    rd_saved_i = 1'b1; #1;
    check("R8 saved read", rd_data_o, 32'h0);
    rd_saved_i = 1'b0; #1;
    check("R8 cur read", rd_data_o, 32'h0000_00D3);

    do_op(1, 0, 0, 0, 1, 32'hA5A5_A5A5, 8'h00, 4'h0, 0, "R2 flags");
    check("R2 literal", cur_psr_o, 32'hA000_00D3);
    do_op(1, 0, 0, 1, 0, 32'h0000_00F1, 8'h00, 4'h0, 0, "R3 ctrl");
    check("R3 R5 literal", cur_psr_o, 32'hA000_00D1);
    do_op(1, 1, 1, 1, 1, 32'h0, 8'hF0, 4'h2, 1, "R7 imm");
    check("R7 R6 literal", saved_psr_o, 32'h0000_000F);
    do_op(1, 1, 1, 0, 1, 32'h0, 8'h03, 4'h1, 1, "R7 wrap");
    check("R7 wrap literal", saved_psr_o, 32'hC000_000F);
    do_op(1, 1, 0, 1, 1, 32'hFFFF_FFFF, 8'h00, 4'h0, 1, "R6 saved mask");
    check("R6 literal", saved_psr_o, 32'hF000_00EF);
    do_op(1, 0, 0, 1, 1, 32'h0000_0010, 8'h00, 4'h0, 0, "R4 enter user");
    check("R4 mode user", {27'd0, mode_o}, 32'h10);
    do_op(1, 0, 0, 1, 0, 32'hFFFF_FFEF, 8'h00, 4'h0, 0, "R4 ctrl locked");
    check("R4 literal", cur_psr_o, 32'h0000_0010);
    do_op(1, 0, 0, 1, 1, 32'h5000_00FF, 8'h00, 4'h0, 0, "R4 flags in user");
    check("R4 flags literal", cur_psr_o, 32'h5000_0010);
    do_op(1, 1, 0, 1, 0, 32'h0000_0000, 8'h00, 4'h0, 1, "R6 saved from user");
    do_op(1, 0, 0, 0, 0, 32'hFFFF_FFFF, 8'h00, 4'h0, 0, "R9 no field");
    do_op(0, 1, 0, 1, 1, 32'hFFFF_FFFF, 8'h00, 4'h0, 1, "R9 no strobe");
    do_op(1, 1, 0, 0, 1, 32'h3000_0000, 8'h00, 4'h0, 0, "R10 saved only");

    for (int k = 0; k < 1500; k++) begin
      if (k % 60 == 0) do_reset();
      do_op(($urandom % 10) < 7, $urandom % 3 == 0, $urandom % 2 == 1,
            $urandom % 2 == 1, $urandom % 2 == 1, $urandom, 8'($urandom), 4'($urandom),
            $urandom % 2 == 1, "R5 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule